// File: doc/BRIEF.md
# Conversion Word Formatter with Status Flags

This block sits behind a decimation filter. Each time the filter presents a wide signed result with a valid strobe, the block builds one 24-bit output word. The result is saturated to the selected data width in two's complement. Alongside it go two status flags: one says the result was out of range, the other says the modulator has been oscillating recently. The word is registered and appears one clock after the input strobe, together with its own strobe.

A parameter chooses between a 20-bit data field and a 16-bit data field. In the narrow variant, the four bits above the field are zero. The oscillation flag is driven by a small state machine with three states:
- `OSC_CLEAR` (no recent oscillation).
- `OSC_PRESENT` (the last word saw oscillation).
- `OSC_DRAIN` (the modulator has recovered, and a hold count is running down).

The state machine moves only on input strobes:
- CLEAR to PRESENT when oscillation is reported.
- PRESENT stays in PRESENT while oscillation persists.
- PRESENT to DRAIN on the first stable word, or straight to CLEAR when the hold is one word.
- DRAIN to PRESENT when oscillation returns, which reloads the count.
- DRAIN to CLEAR when the last held word is produced.

Top module: `conv_word_fmt`

## Requirements
- R1: Bits 23 and 20 of every output word are 0.
- R2: Bit 22 is 1 exactly when the input result lies outside the signed range of the selected data width (20-bit: -524288..524287, 16-bit: -32768..32767), else 0.
- R3: A result above positive full scale produces data 0x7FFFF (20-bit) or 0x7FFF (16-bit).
- R4: A result below negative full scale produces data 0x80000 (20-bit) or 0x8000 (16-bit).
- R5: An in-range result appears unchanged as two's complement in the data field, which is bits 19..0 for the 20-bit width.
- R6: With the 16-bit width, data sits in bits 15..0 and bits 19..16 are 0.
- R7: Bit 21 is 1 for any word whose strobe arrives while the oscillation input is high.
- R8: After the oscillation input is low again, bit 21 stays 1 for the next four words and is 0 from the fifth. Any oscillation report restarts the four-word hold.
- R9: Bits 21 and 22 are independent: every combination of the two can occur.
- R10: Without an input strobe, out_valid stays low, out_word holds its value, and the hold count does not advance.
- R11: out_valid is a single-cycle pulse one clock after each in_valid, and the word it qualifies is registered in that same edge.
- R12: After reset, out_valid and out_word are 0, and the state machine is in `OSC_CLEAR`: a first word without oscillation has bit 21 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Filter result strobe |
| in_result | input | IN_W | Signed filter result |
| osc_detect | input | 1 | Modulator oscillation level |
| out_valid | output | 1 | Output word strobe |
| out_word | output | 24 | Formatted word |

## Verification
The data path is swept over a dense grid of inputs from far below to far above full scale. Each boundary value is also applied exactly, together with its neighbours one step inside and outside. The same stimulus drives a 20-bit and a 16-bit instance at once, so a value near ±2^15 lands in range for one and clamps for the other, which separates the two widths' limits. The oscillation input follows a periodic burst pattern whose gaps are shorter than, equal to and longer than the hold. This separates a correct reload from a count that only starts at zero or only counts elapsed cycles. An idle stretch between strobes shows whether the count advances without output words.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    localparam int WORD_W = 24;
    localparam int WIDE_DW = 20;
    localparam int NARROW_DW = 16;

    typedef enum logic [1:0] {
        OSC_CLEAR   = 2'd0,
        OSC_PRESENT = 2'd1,
        OSC_DRAIN   = 2'd2
    } osc_state_t;
endpackage

// File: rtl/cwf_sat.sv
module cwf_sat #(
    parameter int IN_W  = 24,
    parameter int OUT_W = 20
) (
    input  logic signed [IN_W-1:0] raw,
    output logic [OUT_W-1:0]       field,
    output logic                   out_of_range
);
    localparam int EXT_W = IN_W - OUT_W + 1;

    logic [EXT_W-1:0] head;

    always_comb begin
        head = raw[IN_W-1:OUT_W-1];
        out_of_range = !((&head) || (~|head));
        if (out_of_range) begin
            field = raw[IN_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                : {1'b0, {(OUT_W-1){1'b1}}};
        end else begin
            field = raw[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/cwf_osc_fsm.sv
module cwf_osc_fsm
    import cwf_pkg::*;
#(
    parameter int HOLD_WORDS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic osc_level,
    output logic flag
);
    localparam int CNT_W = $clog2(HOLD_WORDS + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_WORDS);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    osc_state_t       st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= OSC_CLEAR;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        flag  = osc_level || (st != OSC_CLEAR);
        if (strobe) begin
            unique case (st)
                OSC_CLEAR: begin
                    if (osc_level) begin
                        st_n  = OSC_PRESENT;
                        cnt_n = HOLD_V;
                    end
                end
                OSC_PRESENT: begin
                    if (osc_level) begin
                        cnt_n = HOLD_V;
                    end else begin
                        cnt_n = HOLD_V - ONE_V;
                        st_n  = (HOLD_V == ONE_V) ? OSC_CLEAR : OSC_DRAIN;
                    end
                end
                OSC_DRAIN: begin
                    if (osc_level) begin
                        st_n  = OSC_PRESENT;
                        cnt_n = HOLD_V;
                    end else begin
                        cnt_n = cnt - ONE_V;
                        if (cnt == ONE_V) st_n = OSC_CLEAR;
                    end
                end
                default: begin
                    st_n  = OSC_CLEAR;
                    cnt_n = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/cwf_pack.sv
module cwf_pack
    import cwf_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input  logic              ovr,
    input  logic              osc,
    input  logic [DATA_W-1:0] data,
    output logic [WORD_W-1:0] word
);
    generate
        if (DATA_W == WIDE_DW) begin : g_wide
            assign word = {1'b0, ovr, osc, 1'b0, data};
        end else begin : g_narrow
            assign word = {1'b0, ovr, osc, 1'b0, {(WIDE_DW-DATA_W){1'b0}}, data};
        end
    endgenerate
endmodule

// File: rtl/conv_word_fmt.sv
module conv_word_fmt
    import cwf_pkg::*;
#(
    parameter int IN_W       = 24,
    parameter bit NARROW     = 1'b0,
    parameter int HOLD_WORDS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_result,
    input  logic                   osc_detect,
    output logic                   out_valid,
    output logic [WORD_W-1:0]      out_word
);
    localparam int DATA_W = NARROW ? NARROW_DW : WIDE_DW;

    logic [DATA_W-1:0] sat_field;
    logic              sat_ovr;
    logic              osc_flag;
    logic [WORD_W-1:0] packed_word;

    cwf_sat #(.IN_W(IN_W), .OUT_W(DATA_W)) u_sat (
        .raw          (in_result),
        .field        (sat_field),
        .out_of_range (sat_ovr)
    );

    cwf_osc_fsm #(.HOLD_WORDS(HOLD_WORDS)) u_osc (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (in_valid),
        .osc_level (osc_detect),
        .flag      (osc_flag)
    );

    cwf_pack #(.DATA_W(DATA_W)) u_pack (
        .ovr  (sat_ovr),
        .osc  (osc_flag),
        .data (sat_field),
        .word (packed_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_word <= packed_word;
        end
    end
endmodule

// File: rtl/cwf_checker.sv
module cwf_checker #(
    parameter int IN_W       = 24,
    parameter bit NARROW     = 1'b0,
    parameter int HOLD_WORDS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic signed [IN_W-1:0] in_result,
    input logic                   osc_detect,
    input logic                   out_valid,
    input logic [23:0]            out_word
);
    localparam int DW = NARROW ? 16 : 20;
    localparam longint MAXV = (longint'(1) << (DW - 1)) - 1;
    localparam longint MINV = -MAXV - 1;

    longint wide_v;
    assign wide_v = longint'(in_result);

    a_r1_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word[23] == 1'b0 && out_word[20] == 1'b0));

    a_r2_in_range_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_v <= MAXV && wide_v >= MINV) |=> !out_word[22]);

    a_r3_pos_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_v > MAXV) |=> (out_word[22] && out_word[DW-1:0] == DW'(MAXV)));

    a_r4_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_v < MINV) |=> (out_word[22] && out_word[DW-1:0] == DW'(MINV)));

    a_r6_narrow_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && NARROW) |-> (out_word[19:16] == 4'h0));

    a_r7_osc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && osc_detect) |=> out_word[21]);

    a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_word)));

    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
endmodule

bind conv_word_fmt cwf_checker #(
    .IN_W(IN_W), .NARROW(NARROW), .HOLD_WORDS(HOLD_WORDS)
) u_cwf_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_result(in_result),
    .osc_detect(osc_detect), .out_valid(out_valid), .out_word(out_word)
);

// File: tb/tb_conv_word_fmt.sv
module tb_conv_word_fmt;
    localparam int IN_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [IN_W-1:0] in_result = '0;
    logic osc_detect = 1'b0;
    logic out_valid, out_valid16;
    logic [23:0] out_word, out_word16;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int rem = 0;

    always #10 clk = ~clk;

    conv_word_fmt #(.IN_W(IN_W), .NARROW(1'b0), .HOLD_WORDS(4)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_result(in_result),
        .osc_detect(osc_detect), .out_valid(out_valid), .out_word(out_word));

    conv_word_fmt #(.IN_W(IN_W), .NARROW(1'b1), .HOLD_WORDS(4)) dut16 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_result(in_result),
        .osc_detect(osc_detect), .out_valid(out_valid16), .out_word(out_word16));

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] data_exp(input int v, input bit narrow, output bit ovr);
        int mx;
        int mn;
        int d;
        mx = narrow ? 32767 : 524287;
        mn = -mx - 1;
        ovr = (v > mx) || (v < mn);
        d = (v > mx) ? mx : ((v < mn) ? mn : v);
        data_exp = narrow ? {8'h00, 16'(d)} : {4'h0, 20'(d)};
    endfunction

    function automatic string dtag(input int v, input bit narrow);
        int mx;
        mx = narrow ? 32767 : 524287;
        if (v > mx) return narrow ? "R3 R6" : "R3";
        if (v < -mx - 1) return narrow ? "R4 R6" : "R4";
        return narrow ? "R5 R6" : "R5";
    endfunction

    task automatic send_word(input int v, input bit osc);
        bit ovr20, ovr16, oflag;
        logic [23:0] d20, d16;
        @(negedge clk);
        in_result = IN_W'(v);
        osc_detect = osc;
        in_valid = 1'b1;
        if (osc) begin
            oflag = 1'b1;
            rem = 4;
        end else if (rem > 0) begin
            oflag = 1'b1;
            rem--;
        end else begin
            oflag = 1'b0;
        end
        d20 = data_exp(v, 1'b0, ovr20);
        d16 = data_exp(v, 1'b1, ovr16);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 valid", {23'd0, out_valid}, 24'd1);
        chk("R11 valid16", {23'd0, out_valid16}, 24'd1);
        chk("R1 zeros", {22'd0, out_word[23], out_word[20]}, 24'd0);
        chk("R1 zeros16", {22'd0, out_word16[23], out_word16[20]}, 24'd0);
        chk("R2 R9 ovr", {23'd0, out_word[22]}, {23'd0, ovr20});
        chk("R2 R9 ovr16", {23'd0, out_word16[22]}, {23'd0, ovr16});
        chk("R7 R8 osc", {23'd0, out_word[21]}, {23'd0, oflag});
        chk("R7 R8 osc16", {23'd0, out_word16[21]}, {23'd0, oflag});
        chk(dtag(v, 1'b0), {4'h0, out_word[19:0]}, d20);
        chk(dtag(v, 1'b1), {4'h0, out_word16[19:0]}, d16);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] held;
        int k;
        int bounds[] = '{524287, 524288, 524289, -524288, -524289, -524287,
                         32767, 32768, 32769, -32768, -32769, -32767,
                         0, 1, -1, 8388607, -8388608};
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 valid", {23'd0, out_valid}, 24'd0);
        chk("R12 word", out_word, 24'd0);
        chk("R12 word16", out_word16, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: first stable word must carry a clear oscillation flag
        send_word(12345, 1'b0);

        // R2 R3 R4 R5 R6: exact boundaries
        k = 0;
        foreach (bounds[i]) begin
            send_word(bounds[i], (k % 5) == 2);
            k++;
        end

        // R10: idle stretch freezes the output and the hold count
        send_word(100, 1'b1);
        send_word(-100, 1'b0);
        held = out_word;
        repeat (12) begin
            @(negedge clk);
            chk("R10 no valid", {23'd0, out_valid}, 24'd0);
            chk("R10 held", out_word, held);
        end
        send_word(5, 1'b0);
        send_word(6, 1'b0);
        send_word(7, 1'b0);
        send_word(8, 1'b0);

        // R8 R9: dense sweep with oscillation bursts of varying gaps
        k = 0;
        for (int v = -600000; v <= 600000; v += 997) begin
            send_word(v, ((k % 11) < 2) || ((k % 23) == 9));
            k++;
        end
        // R8: reload during hold, then full drain
        send_word(1, 1'b1);
        send_word(2, 1'b0);
        send_word(3, 1'b0);
        send_word(4, 1'b1);
        for (int j = 0; j < 6; j++) send_word(j, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule